// File: doc/BRIEF.md
# Bus Watch Timeout Monitor

This block guards bus accesses whose completion depends on a ready signal from outside the chip's own decoders. When an access to such a region starts, a small counter is cleared and begins to run. If the external device returns ready in time, the watch ends quietly. If it does not, the monitor ends the access itself. For one clock it drives an injected ready together with a bus error, so the processor is released and can handle the fault.

Accesses to regions that the chip terminates internally never start the counter. The whole feature is gated by a configuration enable. While that enable is low, no watch starts, and a watch already running is dropped.

Top module: `bus_watch_monitor`

## Requirements
- R1: The counter is `CNT_W` bits wide (default 5) and its terminal value is `LIMIT` (default 31, at most 2^CNT_W-1). When a watch starts on clock edge t0 and `ext_ready` is low on every edge t0+1 through t0+LIMIT+1, `inj_ready` and `bus_err` are high during the cycle after edge t0+LIMIT+1.
- R2: A watch starts only on an edge where `acc_start`=1, `ext_term`=1 and `watch_en`=1, and the counter then restarts from zero. `ext_ready` seen while no watch is running has no effect on the outputs.
- R3: While `watch_en`=0 no watch starts. An edge with `watch_en`=0 ends a running watch, and no timeout pulse follows it.
- R4: On a timeout, `bus_err` is high in exactly the same cycle as `inj_ready`.
- R5: Each timeout pulse lasts exactly one clock. After a timeout the monitor stays idle until the next qualifying start.
- R6: An access start with `ext_term`=0 never starts a watch, and it ends any watch that is running.
- R7: `ext_ready` high on an edge of a running watch ends that watch with no pulse. This includes the edge on which the counter sits at `LIMIT`.
- R8: A qualifying start while a watch is running restarts the count from zero.
- R9: After reset, both outputs are low and no watch is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| watch_en | input | 1 | Configuration enable for the monitor |
| acc_start | input | 1 | One-clock strobe marking the start of a bus access |
| ext_term | input | 1 | The accessed region is terminated by the external ready |
| ext_ready | input | 1 | Ready returned by the external device |
| inj_ready | output | 1 | Ready injected by the monitor on a timeout |
| bus_err | output | 1 | Bus error flagged with the injected ready |

## Verification
The bench builds the monitor with `CNT_W`=4 and `LIMIT`=15. This makes the terminal value equal to the counter's all-ones code, so the edge where the count would wrap is exercised on every timeout. It also keeps each timeout within a few dozen clocks. With runs this short, many cases fit into one run:
- a ready arriving early;
- a ready arriving exactly on the terminal edge, and one edge too late;
- restarts in mid-watch;
- the enable dropped in mid-watch.

// File: rtl/bw_pkg.sv
package bw_pkg;
  typedef enum logic {BW_IDLE = 1'b0, BW_WATCH = 1'b1} bw_state_e;

  // Next value of the watch counter (no wrap needed: it stops at the limit)
  function automatic logic [15:0] bw_step(input logic [15:0] cur);
    return cur + 16'd1;
  endfunction

  // True when the counter has reached its terminal value
  function automatic logic bw_at_end(input logic [15:0] cur, input int unsigned lim);
    return cur == 16'(lim);
  endfunction
endpackage

// File: rtl/bw_timer.sv
module bw_timer #(
  parameter int CNT_W = 5,
  parameter int LIMIT = (1 << CNT_W) - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             advance,
  output logic [CNT_W-1:0] count,
  output logic             at_limit
);
  import bw_pkg::*;
  localparam int PADW = 16 - CNT_W;

  logic [15:0] wide_cnt;
  assign wide_cnt = {{PADW{1'b0}}, count};
  assign at_limit = bw_at_end(wide_cnt, LIMIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       count <= '0;
    else if (clear)   count <= '0;
    else if (advance) count <= bw_step(wide_cnt)[CNT_W-1:0];
  end

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(LIMIT)); // R1
  AST_HOLD_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    at_limit && !clear |=> count == CNT_W'(LIMIT)); // R1
endmodule

// File: rtl/bw_ctrl.sv
module bw_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic watch_en,
  input  logic acc_start,
  input  logic ext_term,
  input  logic ext_ready,
  input  logic at_limit,
  output logic watching,
  output logic clear,
  output logic advance,
  output logic fire
);
  import bw_pkg::*;

  bw_state_e state, state_nx;
  logic      start_ext;
  logic      stop_watch;

  assign watching   = (state == BW_WATCH);
  assign start_ext  = acc_start && ext_term && watch_en;
  assign fire       = watching && watch_en && !ext_ready && at_limit;
  assign stop_watch = watching && (!watch_en || ext_ready || fire);
  assign clear      = acc_start;
  assign advance    = watching && !acc_start && watch_en && !ext_ready && !at_limit;

  always_comb begin
    state_nx = state;
    if (acc_start)       state_nx = start_ext ? BW_WATCH : BW_IDLE;
    else if (stop_watch) state_nx = BW_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= BW_IDLE;
    else        state <= state_nx;
  end

  AST_INTERNAL_NO_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    acc_start && !ext_term |=> !watching); // R6
  AST_DISABLED_NO_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    !watch_en |=> !watching); // R3
  AST_IDLE_AFTER_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !acc_start |=> !watching); // R5
endmodule

// File: rtl/bus_watch_monitor.sv
module bus_watch_monitor #(
  parameter int CNT_W = 5,
  parameter int LIMIT = (1 << CNT_W) - 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic watch_en,
  input  logic acc_start,
  input  logic ext_term,
  input  logic ext_ready,
  output logic inj_ready,
  output logic bus_err
);
  logic             timer_clear;
  logic             timer_adv;
  logic [CNT_W-1:0] timer_count;
  logic             timer_at_limit;
  logic             watch_active;
  logic             timeout_fire;

  bw_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .watch_en  (watch_en),
    .acc_start (acc_start),
    .ext_term  (ext_term),
    .ext_ready (ext_ready),
    .at_limit  (timer_at_limit),
    .watching  (watch_active),
    .clear     (timer_clear),
    .advance   (timer_adv),
    .fire      (timeout_fire)
  );

  bw_timer #(.CNT_W(CNT_W), .LIMIT(LIMIT)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (timer_clear),
    .advance  (timer_adv),
    .count    (timer_count),
    .at_limit (timer_at_limit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inj_ready <= 1'b0;
      bus_err   <= 1'b0;
    end else begin
      inj_ready <= timeout_fire;
      bus_err   <= timeout_fire;
    end
  end

  AST_FIRE_AT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(inj_ready) |-> $past(timer_at_limit && watch_active)); // R1
  AST_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    inj_ready |=> !inj_ready); // R5
  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !watch_en |=> !bus_err); // R3
  AST_READY_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    ext_ready |=> !bus_err); // R7
  AST_ERR_PAIRED: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err == inj_ready); // R4
  AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    acc_start |=> timer_count == '0); // R8
endmodule

// File: tb/bus_watch_monitor_bench.sv
`timescale 1ns/1ps
module bus_watch_monitor_bench;
  localparam int CW  = 4;
  localparam int LIM = 15;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic watch_en = 1'b0, acc_start = 1'b0, ext_term = 1'b0, ext_ready = 1'b0;
  logic inj_ready, bus_err;

  int checks = 0, errors = 0, cycles = 0;
  string cur_req = "R9";
  bit mdl_on = 1'b0, mdl_rdy = 1'b0, mdl_err = 1'b0;
  int mdl_age = 0;
  int pulses = 0;

  always #10 clk = ~clk;

  bus_watch_monitor #(.CNT_W(CW), .LIMIT(LIM)) u_bus_watch_monitor (
    .clk(clk), .rst_n(rst_n), .watch_en(watch_en), .acc_start(acc_start),
    .ext_term(ext_term), .ext_ready(ext_ready),
    .inj_ready(inj_ready), .bus_err(bus_err));

  // Behavioural reference: age = edges elapsed since the start edge
  always @(posedge clk) begin
    if (!rst_n) begin
      mdl_on = 0; mdl_age = 0; mdl_rdy = 0; mdl_err = 0;
    end else begin
      bit timeout;
      timeout = mdl_on && watch_en && !ext_ready && (mdl_age == LIM);
      mdl_rdy = timeout;
      mdl_err = timeout;
      if (acc_start) begin
        mdl_on = watch_en && ext_term;
        mdl_age = 0;
      end else if (mdl_on) begin
        if (!watch_en || ext_ready || timeout) mdl_on = 0;
        else mdl_age = mdl_age + 1;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if (inj_ready !== mdl_rdy || bus_err !== mdl_err) begin
        errors++;
        $display("FAIL %s: inj_ready=%0b bus_err=%0b expected %0b %0b",
                 cur_req, inj_ready, bus_err, mdl_rdy, mdl_err);
      end
      if (inj_ready === 1'b1) pulses++;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog: cycles=%0d expected <= 20000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic tick(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
    #1;
  endtask

  task automatic start_acc(bit term);
    acc_start = 1'b1; ext_term = term;
    tick(1);
    acc_start = 1'b0; ext_term = 1'b0;
  endtask

  task automatic expect_pulses(int exp, string req);
    checks++;
    if (pulses != exp) begin
      errors++;
      $display("FAIL %s: pulses=%0d expected %0d", req, pulses, exp);
    end
  endtask

  initial begin
    #25;
    checks++;
    if (inj_ready !== 1'b0 || bus_err !== 1'b0) begin
      errors++;
      $display("FAIL R9: outputs=%0b%0b expected 00", inj_ready, bus_err);
    end
    @(negedge clk); #1; rst_n = 1'b1; watch_en = 1'b1;
    tick(3);

    // R7: ready arrives early, no pulse
    cur_req = "R7";
    pulses = 0; start_acc(1); tick(3); ext_ready = 1; tick(1); ext_ready = 0; tick(20);
    expect_pulses(0, "R7");

    // R1 R4 R5: full timeout, exactly one single-clock pulse
    cur_req = "R1";
    pulses = 0; start_acc(1); tick(LIM + 5);
    expect_pulses(1, "R1");
    cur_req = "R5"; tick(20); expect_pulses(1, "R5");

    // R7: ready on the terminal edge (edge t0+LIM+1)
    cur_req = "R7";
    pulses = 0; start_acc(1); tick(LIM); ext_ready = 1; tick(1); ext_ready = 0; tick(5);
    expect_pulses(0, "R7");

    // R1: ready one edge too late still times out
    cur_req = "R1";
    pulses = 0; start_acc(1); tick(LIM + 1); ext_ready = 1; tick(1); ext_ready = 0; tick(5);
    expect_pulses(1, "R1");

    // R6: internally terminated region never arms
    cur_req = "R6";
    pulses = 0; start_acc(0); tick(LIM + 10);
    expect_pulses(0, "R6");
    pulses = 0; start_acc(1); tick(5); start_acc(0); tick(LIM + 10);
    expect_pulses(0, "R6");

    // R3: disabled monitor, then disable mid-watch
    cur_req = "R3";
    watch_en = 0; pulses = 0; start_acc(1); tick(LIM + 10);
    expect_pulses(0, "R3");
    watch_en = 1; start_acc(1); tick(6); watch_en = 0; tick(1); watch_en = 1; tick(LIM + 10);
    expect_pulses(0, "R3");

    // R8: restart mid-watch delays the timeout
    cur_req = "R8";
    pulses = 0; start_acc(1); tick(10); start_acc(1); tick(LIM - 2);
    expect_pulses(0, "R8");
    tick(10); expect_pulses(1, "R8");

    // R2: ready while idle is ignored; R4 pairing via model compare
    cur_req = "R2";
    pulses = 0; ext_ready = 1; tick(4); ext_ready = 0; tick(4);
    expect_pulses(0, "R2");
    cur_req = "R4";
    pulses = 0; start_acc(1); tick(LIM + 4); expect_pulses(1, "R4");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule